// File: doc/BRIEF.md
# Snapshot Match Timer

A free-running 64-bit count advances on a tick from a programmable divider. Six 32-bit compare channels watch the low word of the count. When a channel's value is reached, its sticky status flag is set. A per-channel enable mask decides which flags reach a single combined interrupt line. The sixth channel can also request a chip reset through a short, fixed-length pulse.

Software gets a consistent 64-bit reading in two steps. It issues a snapshot command, which copies both halves of the count into a pair of shadow words on one clock edge. It then reads the shadow words at leisure. Both halves of the live count can also be written directly, so a saved count can be put back after a power-down.

Access is through a simple 32-bit register port with separate read and write strobes and a byte address. Reads are combinational and have no side effects.

Top module: `smt_timer`

## Requirements
- R1: Word offsets are: count low 0x00, count high 0x04, compare channels 0 to 5 at 0x08 up to 0x1C in steps of 4, flags 0x20, enable mask 0x24, reset-request enable 0x28, divider 0x2C, snapshot command 0x30, shadow low 0x34 and shadow high 0x38. After reset every register reads 0. Compare, mask (bits 5:0), reset-request enable (bit 0) and divider read back what was written. The command offset, unused offsets and misaligned addresses read 0.
- R2: A write to 0x30 with bit 0 = 1 copies all 64 count bits into the shadow words on that clock edge. The shadow words then hold that value. A write to 0x30 with bit 0 = 0 leaves them unchanged.
- R3: Writing 1 to flag bit n (0x20) clears it. Writing 0 leaves it as it was.
- R4: The interrupt output is high exactly when some flag bit n and mask bit n are both 1. Flags still set while their mask bit is 0.
- R5: Flag n is set on the advance that makes the low count word equal to compare n. The compare wraps modulo 2^32, and several channels can fire on the same advance.
- R6: The count advances once every 2 × (divider + 1) clock cycles.
- R7: A write to 0x00 or 0x04 loads that half on the write edge and leaves the other half unchanged. No advance happens on that edge. An advance past 0xFFFFFFFF in the low word carries into the high word.
- R8: When bit 0 of 0x28 is 1, a channel 5 hit drives the reset-request output high for exactly 4 clock cycles. When that bit is 0, a channel 5 hit sets flag 5 but gives no pulse.
- R9: If a hit on channel n and a write of 1 to flag bit n fall on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer and bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe; read data is 0 when low |
| bus_addr_i | input | 6 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| irq_o | output | 1 | Combined masked interrupt |
| wdog_rst_o | output | 1 | Reset-request pulse |

## Verification
A compare hit and a software clear of the same flag can land on the same edge, and only R9 decides the outcome. To provoke this, the count is parked one below the compare value under a very large divider. The divider is then written to 0, which forces an advance in the very next cycle, and a write-1 to that flag is placed on exactly that edge. The check reads the flag back as set and reads the snapshot low word at the compare value. A second clear then reads back 0. The reset-request pulse is started the same way, so its width can be counted cycle by cycle.

// File: rtl/smt_pkg.sv
package smt_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 6;
  localparam int NCH      = 6;
  localparam int WD_CH    = NCH - 1;
  localparam int WD_PULSE = 4;
  localparam int WORD_W   = ADDR_W - 2;

  localparam logic [WORD_W-1:0] W_CNT_LO = 4'h0;
  localparam logic [WORD_W-1:0] W_CNT_HI = 4'h1;
  localparam logic [WORD_W-1:0] W_MATCH0 = 4'h2;
  localparam logic [WORD_W-1:0] W_STAT   = 4'h8;
  localparam logic [WORD_W-1:0] W_IEN    = 4'h9;
  localparam logic [WORD_W-1:0] W_WDEN   = 4'hA;
  localparam logic [WORD_W-1:0] W_DIV    = 4'hB;
  localparam logic [WORD_W-1:0] W_LATCH  = 4'hC;
  localparam logic [WORD_W-1:0] W_LAT_LO = 4'hD;
  localparam logic [WORD_W-1:0] W_LAT_HI = 4'hE;
endpackage

// File: rtl/smt_prescaler.sv
module smt_prescaler #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] div_i,
  output logic          tick_o
);
  logic [DW:0] pre_q, pre_d, lim;

  assign lim    = {div_i, 1'b1};
  assign tick_o = (pre_q >= lim);

  always_comb begin
    pre_d = tick_o ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_d;
  end
endmodule

// File: rtl/smt_counter64.sv
module smt_counter64 #(
  parameter int HW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            wr_lo_i,
  input  logic            wr_hi_i,
  input  logic [HW-1:0]   wdata_i,
  input  logic            latch_i,
  output logic [2*HW-1:0] cnt_o,
  output logic [2*HW-1:0] lat_o,
  output logic            adv_o
);
  logic [2*HW-1:0] cnt_q, cnt_d, lat_q, lat_d;

  assign adv_o = tick_i & ~(wr_lo_i | wr_hi_i);

  always_comb begin
    cnt_d = cnt_q;
    if (adv_o)   cnt_d = cnt_q + 1'b1;
    if (wr_lo_i) cnt_d[HW-1:0] = wdata_i;
    if (wr_hi_i) cnt_d[2*HW-1:HW] = wdata_i;
    lat_d = latch_i ? cnt_q : lat_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lat_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      lat_q <= lat_d;
    end
  end

  assign cnt_o = cnt_q;
  assign lat_o = lat_q;
endmodule

// File: rtl/smt_match_bank.sv
module smt_match_bank #(
  parameter int NCH = 6,
  parameter int DW  = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    adv_i,
  input  logic [DW-1:0]           cnt_lo_i,
  input  logic [NCH-1:0]          wr_en_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic [NCH-1:0]          clr_i,
  output logic [NCH-1:0][DW-1:0]  match_o,
  output logic [NCH-1:0]          status_o,
  output logic                    last_hit_o
);
  logic [DW-1:0]  next_lo;
  logic [NCH-1:0] hit, status_q, status_d;

  assign next_lo = cnt_lo_i + 1'b1;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [DW-1:0] m_q, m_d;
    always_comb m_d = wr_en_i[ch] ? wdata_i : m_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) m_q <= '0;
      else         m_q <= m_d;
    end
    assign hit[ch]     = adv_i & (next_lo == m_q);
    assign match_o[ch] = m_q;
  end

  // a new hit wins over a clear on the same edge
  always_comb status_d = (status_q & ~clr_i) | hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= status_d;
  end

  assign status_o   = status_q;
  assign last_hit_o = hit[NCH-1];
endmodule

// File: rtl/smt_wdog_pulse.sv
module smt_wdog_pulse #(
  parameter int LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic rst_req_o
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (fire_i)           cnt_d = CW'(LEN);
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    else                  cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign rst_req_o = (cnt_q != '0);
endmodule

// File: rtl/smt_timer.sv
module smt_timer
  import smt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              wdog_rst_o
);
  logic [1:0] rsync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= '0;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  logic [WORD_W-1:0] word;
  logic              aligned, wr_ok;
  assign word    = bus_addr_i[ADDR_W-1:2];
  assign aligned = (bus_addr_i[1:0] == 2'b00);
  assign wr_ok   = bus_wr_i & aligned;

  logic wr_lo, wr_hi, latch_cmd;
  logic [NCH-1:0] match_we, clr;
  assign wr_lo     = wr_ok && (word == W_CNT_LO);
  assign wr_hi     = wr_ok && (word == W_CNT_HI);
  assign latch_cmd = wr_ok && (word == W_LATCH) && bus_wdata_i[0];
  assign clr       = (wr_ok && (word == W_STAT)) ? bus_wdata_i[NCH-1:0] : '0;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_mwe
    assign match_we[ch] = wr_ok && (word == W_MATCH0 + WORD_W'(ch));
  end

  logic [NCH-1:0]    ien_q, ien_d;
  logic              wden_q, wden_d;
  logic [DATA_W-1:0] div_q, div_d;

  always_comb begin
    ien_d  = (wr_ok && word == W_IEN)  ? bus_wdata_i[NCH-1:0] : ien_q;
    wden_d = (wr_ok && word == W_WDEN) ? bus_wdata_i[0]       : wden_q;
    div_d  = (wr_ok && word == W_DIV)  ? bus_wdata_i          : div_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= '0;
      wden_q <= 1'b0;
      div_q  <= '0;
    end else begin
      ien_q  <= ien_d;
      wden_q <= wden_d;
      div_q  <= div_d;
    end
  end

  logic                     tick, adv, last_hit;
  logic [2*DATA_W-1:0]      cnt, lat;
  logic [NCH-1:0][DATA_W-1:0] match;
  logic [NCH-1:0]           status;

  smt_prescaler #(.DW(DATA_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_n), .div_i(div_q), .tick_o(tick)
  );

  smt_counter64 #(.HW(DATA_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_n), .tick_i(tick), .wr_lo_i(wr_lo),
    .wr_hi_i(wr_hi), .wdata_i(bus_wdata_i), .latch_i(latch_cmd),
    .cnt_o(cnt), .lat_o(lat), .adv_o(adv)
  );

  smt_match_bank #(.NCH(NCH), .DW(DATA_W)) u_mb (
    .clk_i(clk_i), .rst_ni(rst_n), .adv_i(adv), .cnt_lo_i(cnt[DATA_W-1:0]),
    .wr_en_i(match_we), .wdata_i(bus_wdata_i), .clr_i(clr),
    .match_o(match), .status_o(status), .last_hit_o(last_hit)
  );

  smt_wdog_pulse #(.LEN(WD_PULSE)) u_wd (
    .clk_i(clk_i), .rst_ni(rst_n), .fire_i(last_hit & wden_q),
    .rst_req_o(wdog_rst_o)
  );

  assign irq_o = |(status & ien_q);

  always_comb begin
    bus_rdata_o = '0;
    if (bus_rd_i && aligned) begin
      case (word)
        W_CNT_LO: bus_rdata_o = cnt[DATA_W-1:0];
        W_CNT_HI: bus_rdata_o = cnt[2*DATA_W-1:DATA_W];
        W_STAT:   bus_rdata_o = DATA_W'(status);
        W_IEN:    bus_rdata_o = DATA_W'(ien_q);
        W_WDEN:   bus_rdata_o = DATA_W'(wden_q);
        W_DIV:    bus_rdata_o = div_q;
        W_LAT_LO: bus_rdata_o = lat[DATA_W-1:0];
        W_LAT_HI: bus_rdata_o = lat[2*DATA_W-1:DATA_W];
        default: begin
          for (int ch = 0; ch < NCH; ch++)
            if (word == W_MATCH0 + WORD_W'(ch)) bus_rdata_o = match[ch];
        end
      endcase
    end
  end
endmodule

// File: rtl/smt_timer_chk.sv
module smt_timer_chk (
  input logic        clk_i,
  input logic        rst_n,
  input logic        latch_cmd,
  input logic [63:0] cnt,
  input logic [63:0] lat,
  input logic [5:0]  status,
  input logic [5:0]  clr,
  input logic [5:0]  ien_q,
  input logic        irq_o,
  input logic        tick,
  input logic        wr_lo,
  input logic        wr_hi,
  input logic        wdog_rst_o,
  input logic        wden_q
);
  AST_LATCH_SNAP: assert property (@(posedge clk_i) disable iff (!rst_n)
    latch_cmd |=> (lat == $past(cnt)));                               // R2
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    !latch_cmd |=> $stable(lat));                                     // R2
  AST_W1C_KEEP: assert property (@(posedge clk_i) disable iff (!rst_n)
    (($past(status) & ~$past(clr) & ~status) == 6'd0));               // R3
  AST_MASK_GATE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ien_q == 6'd0) |-> !irq_o);                                      // R4
  AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!tick && !wr_lo && !wr_hi) |=> $stable(cnt));                    // R6
  AST_HALF_WRITE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> (cnt[63:32] == $past(cnt[63:32])));         // R7
  AST_WDOG_LEN: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(wdog_rst_o) |=> wdog_rst_o ##1 wdog_rst_o ##1 wdog_rst_o ##1 !wdog_rst_o); // R8
  AST_WDOG_GATED: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(wdog_rst_o) |-> $past(wden_q));                             // R8
endmodule

bind smt_timer smt_timer_chk chk_i (
  .clk_i(clk_i), .rst_n(rst_n), .latch_cmd(latch_cmd), .cnt(cnt), .lat(lat),
  .status(status), .clr(clr), .ien_q(ien_q), .irq_o(irq_o), .tick(tick),
  .wr_lo(wr_lo), .wr_hi(wr_hi), .wdog_rst_o(wdog_rst_o), .wden_q(wden_q)
);

// File: tb/smt_timer_tb_top.sv
module smt_timer_tb_top;
  localparam logic [5:0] A_LO = 6'h00, A_HI = 6'h04, A_M0 = 6'h08, A_M1 = 6'h0C,
    A_M2 = 6'h10, A_M5 = 6'h1C, A_ST = 6'h20, A_IEN = 6'h24, A_WDEN = 6'h28,
    A_DIV = 6'h2C, A_LAT = 6'h30, A_SLO = 6'h34, A_SHI = 6'h38;
  localparam logic [31:0] FRZ = 32'h00FF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic wr = 1'b0, rd = 1'b0, raw = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, wdog;

  smt_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .wdog_rst_o(wdog)
  );

  int checks = 0, errors = 0;
  longint cyc = 0, last_edge = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    #2;
    if (rd && !raw) begin
      if (exp_q.size() == 0) chk("scoreboard empty", 1, 0);
      else chk(tag_q.pop_front(), {32'h0, rdata}, {32'h0, exp_q.pop_front()});
    end
  end

  task automatic wr_reg(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1; last_edge = cyc + 1;
    @(posedge clk);
    #1 wr = 1'b0;
  endtask

  task automatic wr_at(longint edge_idx, logic [5:0] a, logic [31:0] d);
    do @(negedge clk); while (cyc + 1 != edge_idx);
    addr = a; wdata = d; wr = 1'b1; last_edge = cyc + 1;
    @(posedge clk);
    #1 wr = 1'b0;
  endtask

  task automatic rd_exp(logic [5:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    addr = a; rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    #3 rd = 1'b0;
  endtask

  task automatic rd_val(logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a; rd = 1'b1; raw = 1'b1;
    #2 v = rdata;
    #1 rd = 1'b0; raw = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] v1, v2;
    int hi_cnt;
    logic s0, s1;
    longint a;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    @(negedge clk);
    chk("R1 irq reset", irq, 0);
    chk("R8 wdog reset", wdog, 0);
    rd_exp(A_SLO, 0, "R1 shadow lo reset");
    rd_exp(A_SHI, 0, "R1 shadow hi reset");
    rd_exp(A_ST, 0, "R1 flags reset");
    rd_exp(A_IEN, 0, "R1 mask reset");
    rd_exp(A_DIV, 0, "R1 divider reset");
    rd_exp(A_M0, 0, "R1 compare reset");

    // R1 readback
    wr_reg(A_DIV, FRZ);
    rd_exp(A_DIV, FRZ, "R1 divider rb");
    wr_reg(A_M2, 32'hA5A5_0000);
    rd_exp(A_M2, 32'hA5A5_0000, "R1 compare rb");
    wr_reg(A_IEN, 32'hFFFF_FFFF);
    rd_exp(A_IEN, 32'h3F, "R1 mask rb");
    wr_reg(A_IEN, 0);
    wr_reg(A_WDEN, 32'hFFFF_FFFF);
    rd_exp(A_WDEN, 1, "R1 wden rb");
    wr_reg(A_WDEN, 0);
    rd_exp(6'h3C, 0, "R1 unmapped");
    rd_exp(A_LAT, 0, "R1 command reads 0");
    rd_exp(6'h0A, 0, "R1 misaligned");

    // R2 / R7 snapshot and direct load
    wr_reg(A_LO, 32'h1234_5678);
    wr_reg(A_HI, 32'h9ABC_DEF0);
    wr_reg(A_LAT, 1);
    rd_exp(A_SLO, 32'h1234_5678, "R2 snap lo");
    rd_exp(A_SHI, 32'h9ABC_DEF0, "R2 snap hi");
    wr_reg(A_HI, 32'h11);
    wr_reg(A_LAT, 0);
    rd_exp(A_SHI, 32'h9ABC_DEF0, "R2 bit0=0 no snap");
    wr_reg(A_LAT, 1);
    rd_exp(A_SLO, 32'h1234_5678, "R7 lo kept on hi write");
    rd_exp(A_SHI, 32'h11, "R7 hi loaded");

    // R7 carry, R5 wrap hits, R4 flags set while masked
    wr_reg(A_LO, 32'hFFFF_FFFE);
    wr_reg(A_HI, 7);
    wr_reg(A_DIV, 0);
    repeat (10) @(posedge clk);
    wr_reg(A_DIV, FRZ);
    wr_reg(A_LAT, 1);
    rd_exp(A_SHI, 8, "R7 carry into hi");
    rd_exp(A_ST, 32'h3B, "R5 wrap hits channels at 0");
    @(negedge clk);
    chk("R4 masked flags no irq", irq, 0);
    wr_reg(A_ST, 32'h3F);

    // R6 rate, divider 0
    wr_reg(A_DIV, 0);
    repeat (4) @(posedge clk);
    wr_reg(A_LAT, 1);
    a = last_edge;
    rd_val(A_SLO, v1);
    wr_at(a + 40, A_LAT, 1);
    rd_val(A_SLO, v2);
    chk("R6 div0 20 advances", v2 - v1, 20);
    // R6 rate, divider 2
    wr_reg(A_DIV, 2);
    repeat (8) @(posedge clk);
    wr_reg(A_LAT, 1);
    a = last_edge;
    rd_val(A_SLO, v1);
    wr_at(a + 120, A_LAT, 1);
    rd_val(A_SLO, v2);
    chk("R6 div2 20 advances", v2 - v1, 20);
    wr_reg(A_DIV, FRZ);

    // R5 / R4 / R3 on channel 1
    wr_reg(A_ST, 32'h3F);
    wr_reg(A_M1, 32'h20);
    wr_reg(A_LO, 32'h10);
    wr_reg(A_IEN, 32'h02);
    wr_reg(A_DIV, 0);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R5 no early hit irq", irq, 0);
    rd_exp(A_ST, 0, "R5 no early flag");
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk("R4 irq on masked-in flag", irq, 1);
    rd_exp(A_ST, 32'h02, "R5 channel 1 flag");
    wr_reg(A_DIV, FRZ);
    wr_reg(A_IEN, 0);
    @(negedge clk);
    chk("R4 mask off drops irq", irq, 0);
    rd_exp(A_ST, 32'h02, "R4 flag kept when masked");
    wr_reg(A_ST, 32'h01);
    rd_exp(A_ST, 32'h02, "R3 write 0 keeps flag");
    wr_reg(A_ST, 32'h02);
    rd_exp(A_ST, 0, "R3 write 1 clears flag");

    // R9 hit and clear on the same edge
    wr_reg(A_ST, 32'h3F);
    wr_reg(A_M0, 32'h500);
    wr_reg(A_LO, 32'h4FF);
    wr_reg(A_DIV, 0);
    wr_reg(A_ST, 32'h01);
    wr_reg(A_DIV, FRZ);
    rd_exp(A_ST, 32'h01, "R9 set wins over clear");
    wr_reg(A_LAT, 1);
    rd_exp(A_SLO, 32'h500, "R5 hit at compare value");
    wr_reg(A_ST, 32'h01);
    rd_exp(A_ST, 0, "R9 later clear works");

    // R8 watchdog pulse
    wr_reg(A_ST, 32'h3F);
    wr_reg(A_M5, 32'h40);
    wr_reg(A_LO, 32'h3F);
    wr_reg(A_WDEN, 1);
    wr_reg(A_DIV, 0);
    hi_cnt = 0; s0 = 1'b0; s1 = 1'b0;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      if (i == 0) s0 = wdog;
      if (i == 1) s1 = wdog;
      if (wdog) hi_cnt++;
    end
    chk("R8 pulse starts after hit", {s0, s1}, 2'b01);
    chk("R8 pulse width", hi_cnt, 4);
    wr_reg(A_DIV, FRZ);
    rd_exp(A_ST, 32'h20, "R8 channel 5 flag");
    // R8 disabled
    wr_reg(A_ST, 32'h3F);
    wr_reg(A_LO, 32'h3F);
    wr_reg(A_WDEN, 0);
    wr_reg(A_DIV, 0);
    hi_cnt = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (wdog) hi_cnt++;
    end
    chk("R8 no pulse when disabled", hi_cnt, 0);
    wr_reg(A_DIV, FRZ);
    rd_exp(A_ST, 32'h20, "R8 flag still set when disabled");

    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) chk("scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule